// File: doc/BRIEF.md
# MAC Address Learning Table

This block is the forwarding database of an eight-port Ethernet switch. Each received frame is presented once, after its header has arrived. The block takes the destination address, the source address and the ingress port. One cycle later it returns an eight-bit mask of the ports that should transmit the frame. A known unicast destination goes to the single port it was learned on. A group destination, or a unicast destination that is not in the table, is flooded inside the ingress port's VLAN. The ingress port is never in the mask.

Source addresses are learned when their frame ends cleanly. The ingress logic signals the end of the frame with a good or bad flag. An entry that sees no traffic is removed by a background sweep. The sweep visits one entry on each prescaled tick, so an idle entry is gone after two full passes over the table. The index into the 1024-entry table is either the low address bits or an XOR fold of the whole address. Every entry keeps the full address, so a collision can only overwrite an entry and can never cause a false hit.

Top module: `mac_learn_table`

## Requirements
- R1: After reset `res_valid` is 0 and every entry is invalid, so the first lookup of any unicast destination floods.
- R2: `res_valid` and `res_mask` are registered: they reflect the lookup sampled on the previous rising edge. With no lookup, `res_valid` is 0 and `res_mask` is 0.
- R3: A destination with the group bit set (bit 40 of the 48-bit address, the low bit of the first octet) is sent to every port of the ingress port's VLAN except the ingress port.
- R4: A unicast destination that misses the table is flooded in the same way as R3.
- R5: A unicast destination that hits the table gives a one-hot mask for the learned port when that port is in the ingress VLAN. If the learned port is the ingress port itself, the mask is all zero.
- R6: A unicast hit whose learned port is outside the ingress port's VLAN gives an all-zero mask.
- R7: With `cfg_vlan_split`=1, ports 0-3 and ports 4-7 form two separate groups. With it at 0, all eight ports form one group.
- R8: A source address that misses the table is written only when the next `eof_valid` pulse carries `eof_good`=1. A bad end of frame leaves the table unchanged.
- R9: The group bit (bit 40) of the source address is cleared before the table is searched and before the address is written.
- R10: No learning takes place for a frame whose destination is 48'h0180C2000001.
- R11: With `cfg_hash_mode`=0 the index is address bits [9:0]. With 1, index bit i is the XOR of all address bits j with j mod 10 = i. A new address that maps to an occupied index replaces the old entry.
- R12: With `cfg_age_en`=1, an entry visited twice by the sweep with no source hit in between is invalidated. The sweep visits one entry every TICK_DIV cycles, in ascending index order. A source hit clears the entry's age state. With `cfg_age_en`=0, no entry expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hash_mode | input | 1 | 1: folded hash index, 0: direct low-bit index |
| cfg_age_en | input | 1 | Enables expiry by the sweep |
| cfg_vlan_split | input | 1 | Splits the ports into two VLAN groups |
| lkp_valid | input | 1 | A frame header is presented this cycle |
| lkp_da | input | 48 | Destination address, first octet in bits [47:40] |
| lkp_sa | input | 48 | Source address, same ordering |
| lkp_port | input | 3 | Ingress port |
| eof_valid | input | 1 | End of the last presented frame |
| eof_good | input | 1 | The frame ended without error |
| res_valid | output | 1 | Forwarding result is valid |
| res_mask | output | 8 | Egress port mask |

## Verification
The lookup path is driven with broadcast destinations, unknown unicast destinations, known unicast destinations on another port and on the ingress port, and hits across the VLAN boundary. These cases separate the flood path from the one-hot path and the group mask from source exclusion. Learning is tried with good and bad frame ends, multicast sources and pause destinations, which separates "written" from "never written". Two addresses sharing low bits show eviction in direct mode and coexistence in hash mode. Idle, refreshed and non-ageing entries across several sweep passes show whether expiry depends on traffic and on the enable.

// File: rtl/mlt_pkg.sv
// Shared constants and types for the MAC learning table.
// Assumes addresses are carried with the first octet in bits [47:40].
package mlt_pkg;
    localparam int MAC_W = 48;
    // Group (multicast) bit: low bit of the first transmitted octet
    localparam int GROUP_BIT = 40;
    // Flow-control destination that must not trigger learning
    localparam logic [MAC_W-1:0] PAUSE_DA = 48'h0180C2000001;

    typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/mlt_index.sv
// Table index generator.
// Produces either the low IDX_W address bits or an XOR fold of all address
// bits (bit j feeds index bit j mod IDX_W). Purely combinational.
module mlt_index
    import mlt_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  mac_t             mac,
    input  logic             hash_mode,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] fold;

    // Fold every address bit into its index lane, then pick the mode.
    always_comb begin
        fold = '0;
        for (int j = 0; j < MAC_W; j++) begin
            fold[j % IDX_W] = fold[j % IDX_W] ^ mac[j];
        end
        idx = hash_mode ? fold : mac[IDX_W-1:0];
    end
endmodule

// File: rtl/mlt_flood.sv
// Egress mask builder.
// Computes the VLAN group of the ingress port and produces either a flood
// mask or a single-port mask. The ingress port is always removed.
// Assumes NPORTS is even; the split puts the lower half in one group.
module mlt_flood #(
    parameter int NPORTS = 8,
    parameter int PORT_W = 3
) (
    input  logic              da_mcast,
    input  logic              da_hit,
    input  logic [PORT_W-1:0] da_port,
    input  logic [PORT_W-1:0] src_port,
    input  logic              vlan_split,
    output logic [NPORTS-1:0] mask
);
    localparam int HALF = NPORTS / 2;

    logic [NPORTS-1:0] grp;
    logic [NPORTS-1:0] src_oh;
    logic [NPORTS-1:0] dst_oh;

    // One group-membership bit per port, relative to the ingress port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_grp
        assign grp[p] = !vlan_split ||
                        ((p < HALF) == (src_port < PORT_W'(HALF)));
    end

    assign src_oh = NPORTS'(1) << src_port;
    assign dst_oh = NPORTS'(1) << da_port;

    // Flood for group or unknown destinations, otherwise the single target.
    always_comb begin
        if (da_mcast || !da_hit) begin
            mask = grp & ~src_oh;
        end else begin
            mask = grp & dst_oh & ~src_oh;
        end
    end
endmodule

// File: rtl/mlt_sweep.sv
// Age sweep pacing.
// A prescaler emits one tick every TICK_DIV cycles; each tick advances a
// pointer that walks the whole table and wraps. Synchronous active-low reset.
module mlt_sweep #(
    parameter int TICK_DIV = 7324219,
    parameter int IDX_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick,
    output logic [IDX_W-1:0] ptr
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(TICK_DIV - 1));

    // Prescaler and sweep pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ptr <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
                ptr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mac_learn_table.sv
// MAC learning and forwarding table, one indexed probe per frame.
// Assumes at most one frame is outstanding between a lookup and its
// end-of-frame pulse; a new lookup replaces any pending learn request.
// Table reads are combinational; the result is registered (one cycle).
module mac_learn_table
    import mlt_pkg::*;
#(
    parameter int NPORTS   = 8,
    parameter int PORT_W   = $clog2(NPORTS),
    parameter int IDX_W    = 10,
    parameter int TICK_DIV = 7324219
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hash_mode,
    input  logic              cfg_age_en,
    input  logic              cfg_vlan_split,
    input  logic              lkp_valid,
    input  logic [47:0]       lkp_da,
    input  logic [47:0]       lkp_sa,
    input  logic [PORT_W-1:0] lkp_port,
    input  logic              eof_valid,
    input  logic              eof_good,
    output logic              res_valid,
    output logic [NPORTS-1:0] res_mask
);
    localparam int DEPTH = 1 << IDX_W;

    // Storage
    mac_t              mac_q  [DEPTH];
    logic [PORT_W-1:0] port_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  old_q;

    // Lookup side
    mac_t              sa_clean;
    logic [IDX_W-1:0]  sa_idx;
    logic [IDX_W-1:0]  da_idx;
    logic              sa_hit;
    logic              da_hit;
    logic              is_pause;
    logic [NPORTS-1:0] fwd_mask;

    // Pending learn request
    logic              pend_vld;
    logic [IDX_W-1:0]  pend_idx;
    mac_t              pend_mac;
    logic [PORT_W-1:0] pend_port;
    logic              learn_we;

    // Sweep
    logic              tick;
    logic [IDX_W-1:0]  sweep_ptr;

    assign sa_clean = lkp_sa & ~(mac_t'(1) << GROUP_BIT);
    assign is_pause = (lkp_da == PAUSE_DA);

    mlt_index #(.IDX_W(IDX_W)) u_sa_idx (
        .mac       (sa_clean),
        .hash_mode (cfg_hash_mode),
        .idx       (sa_idx)
    );

    mlt_index #(.IDX_W(IDX_W)) u_da_idx (
        .mac       (lkp_da),
        .hash_mode (cfg_hash_mode),
        .idx       (da_idx)
    );

    assign sa_hit = vld_q[sa_idx] && (mac_q[sa_idx] == sa_clean);
    assign da_hit = vld_q[da_idx] && (mac_q[da_idx] == lkp_da);

    mlt_flood #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_flood (
        .da_mcast   (lkp_da[GROUP_BIT]),
        .da_hit     (da_hit),
        .da_port    (port_q[da_idx]),
        .src_port   (lkp_port),
        .vlan_split (cfg_vlan_split),
        .mask       (fwd_mask)
    );

    mlt_sweep #(.TICK_DIV(TICK_DIV), .IDX_W(IDX_W)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ptr   (sweep_ptr)
    );

    assign learn_we = eof_valid && eof_good && pend_vld;

    // Valid and age state: sweep first, a source hit and a learn override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            old_q <= '0;
        end else begin
            if (tick && cfg_age_en && vld_q[sweep_ptr]) begin
                if (old_q[sweep_ptr]) begin
                    vld_q[sweep_ptr] <= 1'b0;
                end else begin
                    old_q[sweep_ptr] <= 1'b1;
                end
            end
            if (lkp_valid && sa_hit) begin
                vld_q[sa_idx] <= 1'b1;
                old_q[sa_idx] <= 1'b0;
            end
            if (learn_we) begin
                vld_q[pend_idx] <= 1'b1;
                old_q[pend_idx] <= 1'b0;
            end
        end
    end

    // Address and port payload, written only on a learn (RAM-friendly).
    always_ff @(posedge clk) begin
        if (learn_we) begin
            mac_q[pend_idx]  <= pend_mac;
            port_q[pend_idx] <= pend_port;
        end
    end

    // Capture a learn request at lookup; retire it at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_idx  <= '0;
            pend_mac  <= '0;
            pend_port <= '0;
        end else if (lkp_valid) begin
            pend_vld  <= !sa_hit && !is_pause;
            pend_idx  <= sa_idx;
            pend_mac  <= sa_clean;
            pend_port <= lkp_port;
        end else if (eof_valid) begin
            pend_vld  <= 1'b0;
        end
    end

    // Registered forwarding result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_mask  <= '0;
        end else begin
            res_valid <= lkp_valid;
            res_mask  <= lkp_valid ? fwd_mask : '0;
        end
    end
endmodule

// File: rtl/mlt_chk.sv
// Protocol and forwarding-rule checker for mac_learn_table, attached by bind.
module mlt_chk #(
    parameter int NPORTS = 8,
    parameter int PORT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_vlan_split,
    input logic              lkp_valid,
    input logic              lkp_mcast,
    input logic [PORT_W-1:0] lkp_port,
    input logic              res_valid,
    input logic [NPORTS-1:0] res_mask
);
    localparam int HALF = NPORTS / 2;

    // R2
    res_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> res_valid);

    // R2
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> (!res_valid && res_mask == '0));

    // R5
    no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_mask & (NPORTS'(1) << $past(lkp_port))) == '0));

    // R7
    vlan_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cfg_vlan_split) && ($past(lkp_port) < PORT_W'(HALF)))
        |-> (res_mask[NPORTS-1:HALF] == '0));

    // R7
    vlan_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cfg_vlan_split) && ($past(lkp_port) >= PORT_W'(HALF)))
        |-> (res_mask[HALF-1:0] == '0));

    // R3
    mcast_flood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(lkp_mcast) && !$past(cfg_vlan_split))
        |-> ($countones(res_mask) == NPORTS - 1));
endmodule

bind mac_learn_table mlt_chk #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_vlan_split (cfg_vlan_split),
    .lkp_valid      (lkp_valid),
    .lkp_mcast      (lkp_da[40]),
    .lkp_port       (lkp_port),
    .res_valid      (res_valid),
    .res_mask       (res_mask)
);

// File: tb/sim_mac_learn_table.sv
// Bench: behavioural table model compared every clock, plus directed checks.
module sim_mac_learn_table;
    localparam int DIV   = 4;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hash_mode = 1'b0;
    logic        cfg_age_en = 1'b0;
    logic        cfg_vlan_split = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_da = '0;
    logic [47:0] lkp_sa = '0;
    logic [2:0]  lkp_port = '0;
    logic        eof_valid = 1'b0;
    logic        eof_good = 1'b0;
    logic        res_valid;
    logic [7:0]  res_mask;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mac_learn_table #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hash_mode(cfg_hash_mode),
        .cfg_age_en(cfg_age_en), .cfg_vlan_split(cfg_vlan_split),
        .lkp_valid(lkp_valid), .lkp_da(lkp_da), .lkp_sa(lkp_sa),
        .lkp_port(lkp_port), .eof_valid(eof_valid), .eof_good(eof_good),
        .res_valid(res_valid), .res_mask(res_mask)
    );

    // ---------------- reference model ----------------
    logic [47:0] m_mac [DEPTH];
    int          m_port [DEPTH];
    bit          m_vld [DEPTH];
    bit          m_old [DEPTH];
    int          m_cnt, m_ptr;
    bit          p_vld;
    int          p_idx, p_port;
    logic [47:0] p_mac;
    bit          exp_v;
    logic [7:0]  exp_m;
    bit          started = 0;

    function automatic int idx_of(logic [47:0] a, bit hash);
        int r = 0;
        if (!hash) return int'(a[9:0]);
        for (int b = 0; b < 48; b++) if (a[b]) r = r ^ (1 << (b % 10));
        return r;
    endfunction

    function automatic logic [7:0] group_of(int p, bit split);
        if (!split) return 8'hFF;
        return (p < 4) ? 8'h0F : 8'hF0;
    endfunction

    function automatic logic [7:0] model_mask(logic [47:0] da, int sp, bit hash, bit split);
        int di = idx_of(da, hash);
        logic [7:0] g = group_of(sp, split);
        logic [7:0] self = 8'h01 << sp;
        if (da[40] || !(m_vld[di] && m_mac[di] == da)) return g & ~self;
        return g & ~self & (8'h01 << m_port[di]);
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_old[i] = 0; end
            m_cnt = 0; m_ptr = 0; p_vld = 0; p_idx = 0; p_port = 0; p_mac = '0;
            exp_v = 0; exp_m = '0;
        end else begin
            logic [47:0] sa_c;
            int si;
            bit hit, tick, old_pv;
            int old_pi, old_pp;
            logic [47:0] old_pm;
            sa_c = lkp_sa; sa_c[40] = 1'b0;
            si = idx_of(sa_c, cfg_hash_mode);
            hit = m_vld[si] && (m_mac[si] == sa_c);
            exp_v = lkp_valid;
            exp_m = lkp_valid ? model_mask(lkp_da, int'(lkp_port), cfg_hash_mode, cfg_vlan_split) : 8'h00;
            old_pv = p_vld; old_pi = p_idx; old_pp = p_port; old_pm = p_mac;
            tick = (m_cnt == DIV - 1);
            m_cnt = tick ? 0 : m_cnt + 1;
            if (tick && cfg_age_en && m_vld[m_ptr]) begin
                if (m_old[m_ptr]) m_vld[m_ptr] = 0; else m_old[m_ptr] = 1;
            end
            if (tick) m_ptr = (m_ptr + 1) % DEPTH;
            if (lkp_valid && hit) begin m_vld[si] = 1; m_old[si] = 0; end
            if (eof_valid && eof_good && old_pv) begin
                m_vld[old_pi] = 1; m_old[old_pi] = 0;
                m_mac[old_pi] = old_pm; m_port[old_pi] = old_pp;
            end
            if (lkp_valid) begin
                p_vld = !hit && (lkp_da != 48'h0180C2000001);
                p_idx = si; p_mac = sa_c; p_port = int'(lkp_port);
            end else if (eof_valid) p_vld = 0;
        end
    end

    // Cycle-by-cycle comparison against the model (R2 and the requirement in force).
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (res_valid !== exp_v || res_mask !== exp_m) begin
                fails++;
                $display("FAIL %s (model, R2): actual valid=%0b mask=%h expected valid=%0b mask=%h",
                         cur_req, res_valid, res_mask, exp_v, exp_m);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string req, logic [7:0] exp);
        checks++;
        if (res_valid !== 1'b1 || res_mask !== exp) begin
            fails++;
            $display("FAIL %s: actual valid=%0b mask=%h expected valid=1 mask=%h",
                     req, res_valid, res_mask, exp);
        end
    endtask

    task automatic lookup(logic [47:0] da, logic [47:0] sa, int p, string req, logic [7:0] exp);
        cur_req = req;
        @(negedge clk);
        lkp_valid = 1; lkp_da = da; lkp_sa = sa; lkp_port = 3'(p);
        @(negedge clk);
        lkp_valid = 0;
        chk(req, exp);
    endtask

    task automatic finish_frame(bit good);
        @(negedge clk);
        eof_valid = 1; eof_good = good;
        @(negedge clk);
        eof_valid = 0; eof_good = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] A   = 48'h020000000111;
    localparam logic [47:0] B   = 48'h020000000222;
    localparam logic [47:0] C   = 48'h020000000333;
    localparam logic [47:0] D   = 48'h020000000444;
    localparam logic [47:0] E   = 48'h020000000555;
    localparam logic [47:0] F1  = 48'h020000000005;
    localparam logic [47:0] F2  = 48'h02AA00000005;
    localparam logic [47:0] PAU = 48'h0180C2000001;

    initial begin
        idle(3);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual res_valid=%0b expected 0", res_valid);
        end
        rst_n = 1;
        idle(2);

        // R1 R4: empty table floods unknown unicast
        lookup(A, B, 3, "R4", 8'hF7);
        finish_frame(1);
        // R5: learned B on port 3
        lookup(B, A, 5, "R5", 8'h08);
        finish_frame(0);
        // R8: bad end of frame, A not learned
        lookup(A, C, 1, "R8", 8'hFD);
        finish_frame(1);
        // R3: broadcast
        lookup(BC, D, 0, "R3", 8'hFE);
        finish_frame(1);
        // R5: destination learned on ingress port
        lookup(B, D, 3, "R5", 8'h00);
        // R6 R7: VLAN split
        @(negedge clk); cfg_vlan_split = 1;
        lookup(B, D, 6, "R6", 8'h00);
        lookup(BC, D, 6, "R7", 8'hB0);
        lookup(A, D, 2, "R7", 8'h0B);
        lookup(C, D, 2, "R7", 8'h02);
        @(negedge clk); cfg_vlan_split = 0;
        // R9: multicast source learned with group bit cleared
        lookup(BC, 48'h030000000A0A, 4, "R9", 8'hEF);
        finish_frame(1);
        lookup(48'h020000000A0A, A, 0, "R9", 8'h10);
        // R10: pause destination suppresses learning
        lookup(PAU, E, 2, "R10", 8'hFB);
        finish_frame(1);
        lookup(E, A, 0, "R10", 8'hFE);
        // R11: direct-mode collision evicts
        lookup(BC, F1, 6, "R11", 8'hBF);
        finish_frame(1);
        lookup(BC, F2, 7, "R11", 8'h7F);
        finish_frame(1);
        lookup(F1, A, 0, "R11", 8'hFE);
        lookup(F2, A, 0, "R11", 8'h80);
        // R11: hash mode keeps both
        @(negedge clk); cfg_hash_mode = 1;
        lookup(BC, F1, 6, "R11", 8'hBF);
        finish_frame(1);
        lookup(BC, F2, 7, "R11", 8'h7F);
        finish_frame(1);
        lookup(F1, A, 0, "R11", 8'h40);
        lookup(F2, A, 0, "R11", 8'h80);
        // R12: ageing of idle entry, survival of refreshed entry
        @(negedge clk); cfg_age_en = 1;
        lookup(BC, A, 5, "R12", 8'hDF);
        finish_frame(1);
        lookup(BC, C, 2, "R12", 8'hFB);
        finish_frame(1);
        for (int k = 0; k < 3; k++) begin
            idle(3000);
            lookup(BC, C, 2, "R12", 8'hFB);
            finish_frame(1);
        end
        lookup(A, D, 0, "R12", 8'hFE);
        lookup(C, D, 0, "R12", 8'h04);
        // R12: ageing disabled keeps entries
        @(negedge clk); cfg_age_en = 0;
        lookup(BC, A, 5, "R12", 8'hDF);
        finish_frame(1);
        idle(9000);
        lookup(A, D, 0, "R12", 8'h20);
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule